// File: doc/BRIEF.md
# Power-Up Hard Reset Sequencer

This block produces the hard reset signals for a transceiver at power-up. Two active-low outputs are held low: one resets the test access port, the other resets the core logic. Both stay low until the power-good input has been high for a minimum hold time. The core output also waits for the reference-clock-valid input. The hold time is a cycle count, computed from the system clock frequency and the required hold in microseconds. Both monitored inputs pass through two-flop synchronizers before the sequencing logic uses them.

Once the hard reset has been released, management logic may write a one to a soft reset control bit. That bit drives a core reset pulse of a fixed, parameterized length and then clears itself. A soft reset is optional, and it never takes the place of the hard reset: a request made while the hard reset is still held is dropped. A ready status shows that the hard reset is released and that no soft reset is in progress.

A low level on power-good at any time sends the block back to the hold state, drives both outputs low and starts a fresh hold period. The mode input selects system operation, in which the test-port reset is released together with the hard reset. In any other mode the test-port reset simply copies the core reset. All pins are plain control and status levels; the block has no streaming interface.

Top module: `pwrup_rst_seq`

## Requirements
- R1: After `pwr_good_i` rises, `core_rst_n_o` and `tap_rst_n_o` stay low for at least HOLD_CYC cycles, where HOLD_CYC = ceil(CLK_HZ × HOLD_US / 1e6). With `refclk_ok_i` already high, they go high no later than HOLD_CYC+6 cycles after the rise.
- R2: `core_rst_n_o` stays low while `refclk_ok_i` is low, even after the hold time has passed. It goes high within 6 cycles of `refclk_ok_i` rising once the hold time has passed.
- R3: With `sys_mode_i`=1, `tap_rst_n_o` goes high together with the hard reset release and stays high during a soft reset pulse.
- R4: With `sys_mode_i`=0, `tap_rst_n_o` equals `core_rst_n_o` at all times, soft reset pulses included.
- R5: When `pwr_good_i` goes low, both reset outputs and `ready_o` are low within 4 cycles, and the soft reset bit reads 0. A later rise of `pwr_good_i` starts a full new hold period.
- R6: A soft reset write (`soft_wr_i`=1) made while the hard reset is held is ignored. `soft_bit_o` stays 0, and the outputs are released at the normal time with no early release.
- R7: A soft reset write made while `ready_o`=1 makes `soft_bit_o` read 1 from the next cycle onward. `core_rst_n_o` is 0 for exactly SOFT_CYC cycles. The bit then clears to 0 by itself and `core_rst_n_o` returns to 1.
- R8: `ready_o` is 1 only when the hard reset is released and `soft_bit_o` is 0.
- R9: While `rst_n` is low, and right after it, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low register reset |
| pwr_good_i | input | 1 | Supplies stable (asynchronous) |
| refclk_ok_i | input | 1 | Reference clock present (asynchronous) |
| sys_mode_i | input | 1 | 1 = system mode, with a separate test-port reset release |
| soft_wr_i | input | 1 | One-cycle write of 1 to the soft reset bit |
| soft_bit_o | output | 1 | Read-back of the self-clearing soft reset bit |
| tap_rst_n_o | output | 1 | Active-low test access port reset |
| core_rst_n_o | output | 1 | Active-low core reset |
| ready_o | output | 1 | Device ready |

## Verification
A table of power-good, clock-valid and mode levels, each held for a set number of cycles, separates four cases. A power-good rise whose hold time has not yet passed must keep both resets low. An elapsed hold time without a valid clock must keep them low too, and a short power-good drop must restart the count rather than resume it. Only the combination of elapsed time and a valid clock may release the resets. Directed tests then place soft reset writes before and after release, and in both modes. These show the difference between a dropped request and a timed pulse, and between a test-port reset that stays high and one that copies the core reset. A power loss during a pulse must clear the bit.

// File: rtl/pwrup_rst_pkg.sv
package pwrup_rst_pkg;
  typedef enum logic [1:0] {
    ST_HOLD     = 2'd0,
    ST_WAIT_CLK = 2'd1,
    ST_RUN      = 2'd2
  } seq_state_e;
endpackage

// File: rtl/sync2_bus.sv
module sync2_bus #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
      end else begin
        meta_q <= async_i[g];
        stab_q <= meta_q;
      end
    end
    assign sync_o[g] = stab_q;
  end
endmodule

// File: rtl/hold_timer.sv
module hold_timer #(
  parameter int LIMIT = 62500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic en_i,
  output logic done_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (clr_i)              cnt_q <= '0;
    else if (en_i && cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == LIM);

  assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM);
  assert_clr_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !done_o);
endmodule

// File: rtl/soft_rst_ctl.sv
module soft_rst_ctl #(
  parameter int PULSE = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic wr_i,
  output logic bit_o
);
  localparam int SW = $clog2(PULSE + 1);
  localparam logic [SW-1:0] LAST = SW'(PULSE - 1);

  logic          bit_q;
  logic [SW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= 1'b0;
      cnt_q <= '0;
    end else if (!run_i) begin
      bit_q <= 1'b0;
      cnt_q <= '0;
    end else if (bit_q) begin
      if (cnt_q == LAST) begin
        bit_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (wr_i) begin
      bit_q <= 1'b1;
      cnt_q <= '0;
    end
  end

  assign bit_o = bit_q;

  assert_set_only_running_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bit_q) |-> $past(run_i));
  assert_pulse_length_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bit_q) && $past(run_i)) |-> ($past(cnt_q) == LAST));
endmodule

// File: rtl/pwrup_rst_seq.sv
module pwrup_rst_seq
  import pwrup_rst_pkg::*;
#(
  parameter int CLK_HZ   = 125_000_000,
  parameter int HOLD_US  = 500,
  parameter int SOFT_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good_i,
  input  logic refclk_ok_i,
  input  logic sys_mode_i,
  input  logic soft_wr_i,
  output logic soft_bit_o,
  output logic tap_rst_n_o,
  output logic core_rst_n_o,
  output logic ready_o
);
  localparam longint HOLD_L   = (longint'(CLK_HZ) * longint'(HOLD_US) + 64'd999_999) / 64'd1_000_000;
  localparam int     HOLD_CYC = int'(HOLD_L);

  logic [1:0] sync_q;
  logic       pg_s, ck_s;
  logic       t_done;
  logic       soft_bit;
  logic       hard_rel;
  seq_state_e state_q, state_d;

  sync2_bus #(.WIDTH(2)) i_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({refclk_ok_i, pwr_good_i}),
    .sync_o  (sync_q)
  );
  assign pg_s = sync_q[0];
  assign ck_s = sync_q[1];

  hold_timer #(.LIMIT(HOLD_CYC)) i_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (!pg_s),
    .en_i   (state_q == ST_HOLD),
    .done_o (t_done)
  );

  always_comb begin
    state_d = state_q;
    if (!pg_s) begin
      state_d = ST_HOLD;
    end else begin
      unique case (state_q)
        ST_HOLD:     if (t_done) state_d = ST_WAIT_CLK;
        ST_WAIT_CLK: if (ck_s)   state_d = ST_RUN;
        ST_RUN:      state_d = ST_RUN;
        default:     state_d = ST_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_HOLD;
    else        state_q <= state_d;
  end

  assign hard_rel = (state_q == ST_RUN);

  soft_rst_ctl #(.PULSE(SOFT_CYC)) i_soft (
    .clk   (clk),
    .rst_n (rst_n),
    .run_i (hard_rel && pg_s),
    .wr_i  (soft_wr_i),
    .bit_o (soft_bit)
  );

  assign soft_bit_o   = soft_bit;
  assign core_rst_n_o = hard_rel && !soft_bit;
  assign tap_rst_n_o  = sys_mode_i ? hard_rel : core_rst_n_o;
  assign ready_o      = hard_rel && !soft_bit;

  assert_clk_before_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hard_rel) |-> $past(ck_s));
  assert_time_before_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hard_rel) |-> $past(pg_s));
  assert_power_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !pg_s |=> (!core_rst_n_o && !tap_rst_n_o && !soft_bit_o));
  assert_ready_implies_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> (core_rst_n_o && tap_rst_n_o && !soft_bit_o));
  assert_tap_sys_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_mode_i && core_rst_n_o) |-> tap_rst_n_o);
endmodule

// File: tb/test_pwrup_rst_seq.sv
module test_pwrup_rst_seq;
  localparam int CLK_HZ   = 100_000;
  localparam int HOLD_US  = 500;
  localparam int SOFT_CYC = 8;
  localparam int HOLD_CYC = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pg = 1'b0, ck = 1'b0, mode = 1'b1, swr = 1'b0;
  logic sbit, tapn, coren, rdy;
  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pwrup_rst_seq #(.CLK_HZ(CLK_HZ), .HOLD_US(HOLD_US), .SOFT_CYC(SOFT_CYC)) i_pwrup_rst_seq (
    .clk(clk), .rst_n(rst_n), .pwr_good_i(pg), .refclk_ok_i(ck), .sys_mode_i(mode),
    .soft_wr_i(swr), .soft_bit_o(sbit), .tap_rst_n_o(tapn), .core_rst_n_o(coren), .ready_o(rdy)
  );

  typedef struct packed {
    logic        pg;
    logic        ck;
    logic        mode;
    logic [15:0] wait_cyc;
    logic        e_core;
    logic        e_tap;
    logic        e_rdy;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VEC [0:7] = '{
    '{1'b0, 1'b0, 1'b1, 16'd5,  1'b0, 1'b0, 1'b0, 4'd9},
    '{1'b1, 1'b0, 1'b1, 16'd45, 1'b0, 1'b0, 1'b0, 4'd1},
    '{1'b1, 1'b0, 1'b1, 16'd20, 1'b0, 1'b0, 1'b0, 4'd2},
    '{1'b1, 1'b1, 1'b1, 16'd6,  1'b1, 1'b1, 1'b1, 4'd2},
    '{1'b1, 1'b1, 1'b0, 16'd2,  1'b1, 1'b1, 1'b1, 4'd4},
    '{1'b0, 1'b1, 1'b1, 16'd4,  1'b0, 1'b0, 1'b0, 4'd5},
    '{1'b1, 1'b1, 1'b1, 16'd40, 1'b0, 1'b0, 1'b0, 4'd5},
    '{1'b1, 1'b1, 1'b1, 16'd20, 1'b1, 1'b1, 1'b1, 4'd1}
  };

  function automatic string tag(input logic [3:0] r);
    case (r)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd4: return "R4";
      4'd5: return "R5";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic soft_write;
    @(negedge clk); swr = 1'b1;
    @(posedge clk);
    @(negedge clk); swr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk);
    chk("R9", "core", coren, 1'b0);
    chk("R9", "tap", tapn, 1'b0);
    chk("R9", "ready", rdy, 1'b0);
    chk("R9", "soft", sbit, 1'b0);
    rst_n = 1'b1;

    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      pg = VEC[i].pg; ck = VEC[i].ck; mode = VEC[i].mode;
      repeat (int'(VEC[i].wait_cyc) - 1) @(negedge clk);
      chk(tag(VEC[i].req), $sformatf("vec%0d core", i), coren, VEC[i].e_core);
      chk(tag(VEC[i].req), $sformatf("vec%0d tap", i), tapn, VEC[i].e_tap);
      chk(tag(VEC[i].req), $sformatf("vec%0d ready", i), rdy, VEC[i].e_rdy);
    end

    // R7 / R3 / R8: soft reset after ready, system mode
    soft_write();
    chk("R7", "bit set", sbit, 1'b1);
    chk("R7", "core low", coren, 1'b0);
    chk("R3", "tap high in pulse", tapn, 1'b1);
    chk("R8", "ready low in pulse", rdy, 1'b0);
    repeat (SOFT_CYC - 1) @(negedge clk);
    chk("R7", "still set at end", sbit, 1'b1);
    @(negedge clk);
    chk("R7", "self-cleared", sbit, 1'b0);
    chk("R7", "core back", coren, 1'b1);
    chk("R8", "ready back", rdy, 1'b1);

    // R4: non-system mode, tap follows core through a pulse
    mode = 1'b0;
    soft_write();
    chk("R4", "tap follows core low", tapn, 1'b0);
    chk("R4", "core low", coren, 1'b0);
    repeat (SOFT_CYC) @(negedge clk);
    chk("R4", "tap follows core high", tapn, 1'b1);
    mode = 1'b1;

    // R5: power loss during a pulse
    soft_write();
    pg = 1'b0;
    repeat (4) @(negedge clk);
    chk("R5", "bit cleared", sbit, 1'b0);
    chk("R5", "core low", coren, 1'b0);
    chk("R5", "tap low", tapn, 1'b0);

    // R6: soft write during hold is ignored; R1 release time
    pg = 1'b1;
    repeat (9) @(negedge clk);
    soft_write();
    chk("R6", "bit ignored", sbit, 1'b0);
    chk("R6", "core held", coren, 1'b0);
    repeat (HOLD_CYC - 11) @(negedge clk);
    chk("R1", "held at HOLD_CYC", coren, 1'b0);
    chk("R6", "no early release", tapn, 1'b0);
    repeat (6) @(negedge clk);
    chk("R1", "released", coren, 1'b1);
    chk("R6", "bit still 0", sbit, 1'b0);
    chk("R8", "ready", rdy, 1'b1);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule